// File: doc/BRIEF.md
# SPI Command Frame Decoder

This block is the device-side serial port of a mixed-signal I/O chip. A host drives 16-bit frames into it, most significant bit first, with a clock that idles high. Each completed frame is decoded into one of four things: a DAC code update, a register write, a request for read data, or a no-op. The block holds a 16-entry register file and eight 12-bit DAC codes, and drives the range and reference control bits from the register file.

Data that the host asks for is never returned in the frame that asks for it. It is staged at the end of that frame and shifted out on MISO during the next one, so the host follows a request with a no-op frame to collect the answer. ADC conversion is not modelled: per-channel sample values arrive on a flat input bus, and the block only tags and returns them. Serial inputs and GPIO pins are sampled in the system clock domain through synchronizers, so the serial clock must be several times slower than the system clock.

Top module: `spi_cmd_decoder`

## Requirements
- R1: A frame is 16 bits, MSB first, framed by an active-low chip select; MOSI is sampled on the falling serial clock edge, MISO advances on the rising edge, and the first MISO bit is valid after chip select falls.
- R2: A frame with bit 15 set writes code bits 11:0 into the DAC channel given by bits 14:12; that code appears on `dac_codes[ch*12 +: 12]`.
- R3: A frame with bit 15 clear stores data bits 10:0 into the register addressed by bits 14:11.
- R4: An all-zero frame changes no register or DAC code.
- R5: A write to address 7 with data bit 6 set makes the next frame return, on MISO, the 11-bit contents of the register whose address is in data bits 5:2, zero-extended to 16 bits.
- R6: A write to address 10 with data bit 10 set makes the next frame return the GPIO pin levels in bits 7:0 and zeros above.
- R7: A write to address 2 with a nonzero mask in data bits 7:0 starts a conversion on the lowest set channel; the next frame returns 0x0000 and, if that frame is a no-op, the frame after returns 0 in bit 15, the channel in bits 14:12 and that channel's sample in bits 11:0. A zero mask starts nothing.
- R8: The frame 0x7DAC (address 15, data 0x5AC) clears every register and every DAC code; any other data to address 15 is an ordinary register write.
- R9: `adc_range_hi` follows bit 5 of register 3, `dac_range_hi` follows bit 4 of register 3, and `int_ref_en` follows bit 9 of register 11.
- R10: Raising chip select before 16 bits have arrived discards the partial frame, and the next full frame decodes normally.
- R11: A frame that requests no data makes the next frame return 0x0000.
- R12: After the synchronous reset, MISO is low, all DAC codes and control outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| gpio_pins | input | 8 | Pin levels returned by GPIO readback |
| adc_samples | input | 96 | Per-channel 12-bit samples, channel k at bits k*12 +: 12 |
| dac_codes | output | 96 | Per-channel 12-bit DAC codes, channel k at bits k*12 +: 12 |
| adc_range_hi | output | 1 | ADC range select |
| dac_range_hi | output | 1 | DAC range select |
| int_ref_en | output | 1 | Internal reference enable |

## Verification
The hardest state to reach is the conversion pipeline's second stage: the result only appears if the start frame is followed by exactly two no-op frames, and any other frame in between must drop it. The bench reaches it by issuing a start with a multi-bit mask, collecting the all-zero placeholder in the first no-op and the tagged sample in the second, and then repeats with a zero mask to show nothing is staged. A truncated frame is produced by raising chip select after seven clocks so the bit counter must recover before the next frame.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 11;

  localparam logic [ADDR_W-1:0] A_CONV_START = 4'h2;
  localparam logic [ADDR_W-1:0] A_CTRL       = 4'h3;
  localparam logic [ADDR_W-1:0] A_READ_ARM   = 4'h7;
  localparam logic [ADDR_W-1:0] A_PIN_ARM    = 4'hA;
  localparam logic [ADDR_W-1:0] A_POWER      = 4'hB;
  localparam logic [ADDR_W-1:0] A_CLEAR      = 4'hF;

  localparam logic [DATA_W-1:0] CLEAR_KEY    = 11'h5AC;
endpackage

// File: rtl/sdec_sync.sv
module sdec_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/sdec_shifter.sv
module sdec_shifter
  import sdec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               cs_s,
  input  logic               mosi_s,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               frame_vld,
  output logic [FRAME_W-1:0] frame_data,
  output logic               miso
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic               sclk_d, cs_d;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] rx_q, tx_q;

  wire sclk_fall = sclk_d & ~sclk_s;
  wire sclk_rise = ~sclk_d & sclk_s;
  wire cs_fall   = cs_d & ~cs_s;
  wire [FRAME_W-1:0] rx_next = {rx_q[FRAME_W-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d     <= 1'b1;
      cs_d       <= 1'b1;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      frame_vld  <= 1'b0;
      frame_data <= '0;
    end else begin
      sclk_d    <= sclk_s;
      cs_d      <= cs_s;
      frame_vld <= 1'b0;
      if (cs_s) begin
        cnt_q <= '0;
      end else if (sclk_fall) begin
        rx_q <= rx_next;
        if (cnt_q == CNT_W'(FRAME_W - 1)) begin
          cnt_q      <= '0;
          frame_vld  <= 1'b1;
          frame_data <= rx_next;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (cs_s)           tx_q <= '0;
      else if (cs_fall)   tx_q <= tx_word;
      else if (sclk_rise) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign miso = tx_q[FRAME_W-1];

  // R1
  frame_sel_chk: assert property (@(posedge clk) disable iff (rst)
    frame_vld |-> $past(!cs_s));
  // R10
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> cnt_q == '0);
  // R12
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !miso);
endmodule

// File: rtl/sdec_core.sv
module sdec_core
  import sdec_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int CODE_W  = 12,
  parameter int GPIO_W  = 8,
  parameter int NUM_REG = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frame_vld,
  input  logic [FRAME_W-1:0]       frame_data,
  input  logic [GPIO_W-1:0]        gpio_s,
  input  logic [NUM_CH*CODE_W-1:0] adc_samples,
  output logic [FRAME_W-1:0]       tx_word,
  output logic [NUM_CH*CODE_W-1:0] dac_codes,
  output logic                     adc_range_hi,
  output logic                     dac_range_hi,
  output logic                     int_ref_en
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [DATA_W-1:0] regs_q [NUM_REG];
  logic [CODE_W-1:0] dac_q  [NUM_CH];
  logic              conv_armed_q;
  logic [CH_W-1:0]   conv_ch_q;

  wire              is_nop  = (frame_data == '0);
  wire              is_dac  = frame_data[FRAME_W-1];
  wire [ADDR_W-1:0] addr    = frame_data[FRAME_W-2 -: ADDR_W];
  wire [DATA_W-1:0] data    = frame_data[DATA_W-1:0];
  wire [CH_W-1:0]   dac_ch  = frame_data[FRAME_W-2 -: CH_W];
  wire [CODE_W-1:0] dac_val = frame_data[CODE_W-1:0];
  wire              is_clr  = !is_dac && addr == A_CLEAR && data == CLEAR_KEY;

  logic [CH_W-1:0] first_ch;
  logic            any_ch;
  always_comb begin
    first_ch = '0;
    any_ch   = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (data[i]) begin
        first_ch = CH_W'(i);
        any_ch   = 1'b1;
      end
    end
  end

  wire [CODE_W-1:0]  conv_sample = adc_samples[conv_ch_q*CODE_W +: CODE_W];
  wire [FRAME_W-1:0] conv_word   = {{(FRAME_W-CH_W-CODE_W){1'b0}}, conv_ch_q, conv_sample};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REG; r++) regs_q[r] <= '0;
      for (int c = 0; c < NUM_CH; c++)  dac_q[c]  <= '0;
      tx_word      <= '0;
      conv_armed_q <= 1'b0;
      conv_ch_q    <= '0;
    end else if (frame_vld) begin
      tx_word      <= '0;
      conv_armed_q <= 1'b0;
      if (is_nop) begin
        if (conv_armed_q) tx_word <= conv_word;
      end else if (is_dac) begin
        dac_q[dac_ch] <= dac_val;
      end else if (is_clr) begin
        for (int r = 0; r < NUM_REG; r++) regs_q[r] <= '0;
        for (int c = 0; c < NUM_CH; c++)  dac_q[c]  <= '0;
      end else begin
        regs_q[addr] <= data;
        if (addr == A_READ_ARM && data[6])
          tx_word <= {{(FRAME_W-DATA_W){1'b0}}, regs_q[data[5:2]]};
        if (addr == A_PIN_ARM && data[10])
          tx_word <= {{(FRAME_W-GPIO_W){1'b0}}, gpio_s};
        if (addr == A_CONV_START && any_ch) begin
          conv_armed_q <= 1'b1;
          conv_ch_q    <= first_ch;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dac_out
    assign dac_codes[g*CODE_W +: CODE_W] = dac_q[g];
  end

  assign adc_range_hi = regs_q[A_CTRL][5];
  assign dac_range_hi = regs_q[A_CTRL][4];
  assign int_ref_en   = regs_q[A_POWER][9];

  // R2
  dac_write_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && is_dac) |=> dac_q[$past(dac_ch)] == $past(dac_val));
  // R4
  nop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && is_nop) |=> dac_codes == $past(dac_codes));
  // R7
  conv_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && !is_dac && addr == A_CONV_START && data[7:0] != '0) |=> (tx_word == '0 && conv_armed_q));
  // R8
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && is_clr) |=> (dac_codes == '0 && !adc_range_hi && !int_ref_en));
  // R9
  ctrl_track_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && !is_dac && addr == A_CTRL) |=> (adc_range_hi == $past(data[5]) && dac_range_hi == $past(data[4])));
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import sdec_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int CODE_W      = 12,
  parameter int GPIO_W      = 8,
  parameter int NUM_REG     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     spi_sclk,
  input  logic                     spi_cs_n,
  input  logic                     spi_mosi,
  output logic                     spi_miso,
  input  logic [GPIO_W-1:0]        gpio_pins,
  input  logic [NUM_CH*CODE_W-1:0] adc_samples,
  output logic [NUM_CH*CODE_W-1:0] dac_codes,
  output logic                     adc_range_hi,
  output logic                     dac_range_hi,
  output logic                     int_ref_en
);
  localparam int SYNC_W = GPIO_W + 3;

  logic [SYNC_W-1:0]  sync_out;
  logic               frame_vld;
  logic [FRAME_W-1:0] frame_data, tx_word;

  sdec_sync #(
    .W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL({{GPIO_W{1'b0}}, 3'b011})
  ) u_sync (
    .clk(clk), .rst(rst),
    .din({gpio_pins, spi_mosi, spi_cs_n, spi_sclk}),
    .dout(sync_out)
  );

  sdec_shifter u_shift (
    .clk(clk), .rst(rst),
    .sclk_s(sync_out[0]), .cs_s(sync_out[1]), .mosi_s(sync_out[2]),
    .tx_word(tx_word), .frame_vld(frame_vld), .frame_data(frame_data),
    .miso(spi_miso)
  );

  sdec_core #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .GPIO_W(GPIO_W), .NUM_REG(NUM_REG)
  ) u_core (
    .clk(clk), .rst(rst),
    .frame_vld(frame_vld), .frame_data(frame_data),
    .gpio_s(sync_out[SYNC_W-1:3]), .adc_samples(adc_samples),
    .tx_word(tx_word), .dac_codes(dac_codes),
    .adc_range_hi(adc_range_hi), .dac_range_hi(dac_range_hi),
    .int_ref_en(int_ref_en)
  );
endmodule

// File: tb/spi_cmd_decoder_test.sv
module spi_cmd_decoder_test;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sclk = 1'b1, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso;
  logic [7:0]  gpio_pins = '0;
  logic [95:0] adc_samples;
  logic [95:0] dac_codes;
  logic        adc_range_hi, dac_range_hi, int_ref_en;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [11:0] exp_dac [8];

  always #5 clk = ~clk;

  spi_cmd_decoder uut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .gpio_pins(gpio_pins),
    .adc_samples(adc_samples), .dac_codes(dac_codes),
    .adc_range_hi(adc_range_hi), .dac_range_hi(dac_range_hi),
    .int_ref_en(int_ref_en)
  );

  function automatic logic [11:0] samp(input int k);
    return 12'h0A0 + 12'(k) * 12'h101;
  endfunction

  function automatic logic [95:0] packed_dac();
    logic [95:0] v;
    for (int k = 0; k < 8; k++) v[k*12 +: 12] = exp_dac[k];
    return v;
  endfunction

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
    rx = '0;
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 15; i > 15 - nbits; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      spi_sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b1;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] tx, output logic [15:0] rx);
    spi_bits(tx, 16, rx);
  endtask

  task automatic t_reset();
    chk("R12 miso", 96'(spi_miso), 96'd0);
    chk("R12 dac_codes", dac_codes, 96'd0);
    chk("R12 ctrl", 96'({adc_range_hi, dac_range_hi, int_ref_en}), 96'd0);
  endtask

  task automatic t_dac();
    logic [15:0] rx;
    xfer(16'hBABC, rx); exp_dac[3] = 12'hABC;
    xfer(16'h8123, rx); exp_dac[0] = 12'h123;
    xfer(16'hFFFF, rx); exp_dac[7] = 12'hFFF;
    chk("R2 dac codes per channel", dac_codes, packed_dac());
    chk("R11 no data after dac write", 96'(rx), 96'd0);
  endtask

  task automatic t_nop();
    logic [15:0] rx;
    xfer(16'h0000, rx);
    chk("R4 nop keeps dac codes", dac_codes, packed_dac());
  endtask

  task automatic t_readback();
    logic [15:0] rx;
    xfer(16'h2AA5, rx);                    // R3: address 5, data 0x2A5
    xfer(16'h3800 | 16'h0040 | 16'h0014, rx); // arm readback of address 5
    xfer(16'h0000, rx);
    chk("R5 R3 register readback (MSB first)", 96'(rx), 96'h02A5);
    xfer(16'h0000, rx);
    chk("R11 second nop returns zero", 96'(rx), 96'd0);
  endtask

  task automatic t_ctrl();
    logic [15:0] rx;
    xfer(16'h1830, rx);
    chk("R9 both ranges set", 96'({adc_range_hi, dac_range_hi}), 96'b11);
    xfer(16'h1810, rx);
    chk("R9 adc range clear dac set", 96'({adc_range_hi, dac_range_hi}), 96'b01);
    xfer(16'h5A00, rx);
    chk("R9 internal reference", 96'(int_ref_en), 96'd1);
  endtask

  task automatic t_gpio();
    logic [15:0] rx;
    gpio_pins = 8'h5A;
    repeat (4) @(negedge clk);
    xfer(16'h5400, rx);
    xfer(16'h0000, rx);
    chk("R6 gpio readback", 96'(rx), 96'h005A);
  endtask

  task automatic t_conv();
    logic [15:0] rx;
    xfer(16'h1020, rx);
    xfer(16'h0000, rx);
    chk("R7 first nop placeholder", 96'(rx), 96'd0);
    xfer(16'h0000, rx);
    chk("R7 channel 5 result", 96'(rx), 96'({4'b0101, samp(5)}));
    xfer(16'h100C, rx);
    xfer(16'h0000, rx);
    xfer(16'h0000, rx);
    chk("R7 lowest set channel 2", 96'(rx), 96'({4'b0010, samp(2)}));
    xfer(16'h1000, rx);
    xfer(16'h0000, rx);
    xfer(16'h0000, rx);
    chk("R7 zero mask starts nothing", 96'(rx), 96'd0);
  endtask

  task automatic t_abort();
    logic [15:0] rx;
    spi_bits(16'h8FFF, 7, rx);
    chk("R10 partial frame discarded", dac_codes, packed_dac());
    xfer(16'h9456, rx); exp_dac[1] = 12'h456;
    chk("R10 next frame decodes", dac_codes, packed_dac());
  endtask

  task automatic t_clear();
    logic [15:0] rx;
    xfer(16'h7DAD, rx);
    chk("R8 wrong key keeps dac", dac_codes, packed_dac());
    chk("R8 wrong key keeps ctrl", 96'({dac_range_hi, int_ref_en}), 96'b11);
    xfer(16'h7DAC, rx);
    for (int k = 0; k < 8; k++) exp_dac[k] = '0;
    chk("R8 clear dac", dac_codes, 96'd0);
    chk("R8 clear ctrl", 96'({adc_range_hi, dac_range_hi, int_ref_en}), 96'd0);
    xfer(16'h3854, rx);
    xfer(16'h0000, rx);
    chk("R8 register 5 cleared", 96'(rx), 96'd0);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) adc_samples[k*12 +: 12] = samp(k);
    for (int k = 0; k < 8; k++) exp_dac[k] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_dac();
    t_nop();
    t_readback();
    t_ctrl();
    t_gpio();
    t_conv();
    t_abort();
    t_clear();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule